// File: doc/BRIEF.md
# Paged Memory Mapping Unit

This block sits between an 8-bit processor with a 16-bit address bus and its memory. It widens every memory access into a 22-bit physical address in a 4 MB space of 256 pages, each 16 KB. The top two address bits pick one of four 16 KB windows. Each window has its own write-only page register, loaded through the processor's I/O space. A page register can hold any page number.

A two-state mode machine decides how windows are translated. The state `MODE_BYPASS` is entered at reset. In it, the four windows show the first 64 KB of the memory chosen by the `boot_sram` strap. The state `MODE_PAGED` uses the page registers. The transition `MODE_BYPASS -> MODE_PAGED` happens when a control-register write has bit 0 set. The transition `MODE_PAGED -> MODE_BYPASS` happens when a control-register write has bit 0 clear. Every other cycle holds the current state. The page number also selects the chip: flash, static RAM or neither. Translation is combinational, so the address and chip selects follow the processor address in the same cycle.

Top module: `page_map_unit`

## Requirements
- R1: The physical address bits 13:0 always equal `cpu_addr[13:0]`.
- R2: An I/O write loads page register k (k = 0..3) from `cpu_wdata`. The write uses I/O address 60h+k on `cpu_addr[7:0]`, with `io_req` and `wr_en` both high. The register loads at the rising clock edge that samples the write.
- R3: In `MODE_PAGED`, `phys_addr[21:14]` equals page register `cpu_addr[15:14]`, and the `boot_sram` strap has no effect.
- R4: After reset the state is `MODE_BYPASS`, and page registers 0..3 hold pages 0, 1, 2 and 3.
- R5: In `MODE_BYPASS`, `phys_addr[21:14]` is `cpu_addr[15:14]` when `boot_sram`=0 (flash pages 0..3). It is 32 + `cpu_addr[15:14]` when `boot_sram`=1 (static RAM pages 32..35).
- R6: An I/O write to address 64h or 65h controls the mode. It enters `MODE_PAGED` when `cpu_wdata[0]`=1 and `MODE_BYPASS` when `cpu_wdata[0]`=0. Bits 7:1 are ignored. Page registers keep their contents across a disable.
- R7: While `mem_req` is high, pages 0..31 assert `flash_cs`, pages 32..63 assert `sram_cs`, and pages 64..255 assert neither. With `mem_req` low, both selects are low. At most one select is ever high.
- R8: The following leave the page registers and the mode unchanged:
  - I/O reads
  - memory writes
  - I/O writes to any other low address byte
  
  `cpu_addr[15:8]` is ignored in I/O decode.
- R9: `phys_addr`, `flash_cs` and `sram_cs` respond to the address in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address; low byte is the I/O port number |
| cpu_wdata | input | 8 | Processor write data |
| mem_req | input | 1 | Memory access in progress |
| io_req | input | 1 | I/O access in progress |
| wr_en | input | 1 | Access is a write |
| boot_sram | input | 1 | Strap: bypass mode shows static RAM instead of flash |
| phys_addr | output | 22 | Translated physical address |
| flash_cs | output | 1 | Flash chip select |
| sram_cs | output | 1 | Static RAM chip select |

## Verification
Reads in bypass mode are made with both strap values, in all four windows. This tells the flash and static RAM bypass maps apart. Paging is enabled while the strap is set, before any register is programmed. This separates strap-driven translation from the identity reset contents of the page registers. The page registers are then loaded with pages from flash, static RAM and unpopulated space. This shows the chip-select boundaries at 32 and 64. Decoy traffic tests that only I/O writes to the exact port numbers have an effect:
- I/O reads
- memory writes
- I/O writes to neighbouring port numbers
- an I/O write with a non-zero high byte

Last, disable and re-enable through the second control address show that register contents survive the mode change.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    typedef enum logic {
        MODE_BYPASS = 1'b0,
        MODE_PAGED  = 1'b1
    } pmu_mode_e;
endpackage

// File: rtl/pmu_io_decode.sv
module pmu_io_decode #(
    parameter int IO_W      = 8,
    parameter int NUM_BLK   = 4,
    parameter int PAGE_BASE = 'h60,
    parameter int CTRL_BASE = 'h64
) (
    input  logic               io_req,
    input  logic               wr_en,
    input  logic [IO_W-1:0]    io_addr,
    output logic [NUM_BLK-1:0] page_we,
    output logic               ctrl_we
);
    localparam logic [IO_W-1:0] CTRL_ADDR = IO_W'(CTRL_BASE);

    logic io_wr;
    assign io_wr = io_req && wr_en;

    for (genvar k = 0; k < NUM_BLK; k++) begin : g_page_dec
        localparam logic [IO_W-1:0] THIS_ADDR = IO_W'(PAGE_BASE + k);
        assign page_we[k] = io_wr && (io_addr == THIS_ADDR);
    end

    // control register answers on an even/odd address pair
    assign ctrl_we = io_wr && (io_addr[IO_W-1:1] == CTRL_ADDR[IO_W-1:1]);
endmodule

// File: rtl/pmu_page_regs.sv
module pmu_page_regs #(
    parameter int NUM_BLK = 4,
    parameter int PAGE_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BLK-1:0]          page_we,
    input  logic [PAGE_W-1:0]           wdata,
    output logic [NUM_BLK*PAGE_W-1:0]   pages_flat
);
    for (genvar k = 0; k < NUM_BLK; k++) begin : g_reg
        logic [PAGE_W-1:0] page_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                page_q <= PAGE_W'(k);
            end else if (page_we[k]) begin
                page_q <= wdata;
            end
        end
        assign pages_flat[k*PAGE_W +: PAGE_W] = page_q;
    end
endmodule

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
    import pmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic enable_bit,
    output logic paged
);
    pmu_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_BYPASS: if (ctrl_we && enable_bit)  state_d = MODE_PAGED;
            MODE_PAGED:  if (ctrl_we && !enable_bit) state_d = MODE_BYPASS;
            default:     state_d = MODE_BYPASS;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MODE_PAGED: paged = 1'b1;
            default:    paged = 1'b0;
        endcase
    end
endmodule

// File: rtl/page_map_unit.sv
module page_map_unit #(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 8,
    parameter int OFS_W       = 14,
    parameter int IO_W        = 8,
    parameter int FLASH_PAGES = 32,
    parameter int SRAM_PAGES  = 32,
    parameter int PAGE_BASE   = 'h60,
    parameter int CTRL_BASE   = 'h64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [7:0]                cpu_wdata,
    input  logic                      mem_req,
    input  logic                      io_req,
    input  logic                      wr_en,
    input  logic                      boot_sram,
    output logic [PAGE_W+OFS_W-1:0]   phys_addr,
    output logic                      flash_cs,
    output logic                      sram_cs
);
    localparam int BLK_W   = ADDR_W - OFS_W;
    localparam int NUM_BLK = 1 << BLK_W;
    localparam logic [PAGE_W-1:0] FLASH_END = PAGE_W'(FLASH_PAGES);
    localparam logic [PAGE_W-1:0] SRAM_END  = PAGE_W'(FLASH_PAGES + SRAM_PAGES);

    logic [NUM_BLK-1:0]        page_we;
    logic                      ctrl_we;
    logic [NUM_BLK*PAGE_W-1:0] pages_flat;
    logic                      paged;
    logic [BLK_W-1:0]          blk;
    logic [PAGE_W-1:0]         bypass_page;
    logic [PAGE_W-1:0]         page_sel;

    pmu_io_decode #(
        .IO_W(IO_W), .NUM_BLK(NUM_BLK),
        .PAGE_BASE(PAGE_BASE), .CTRL_BASE(CTRL_BASE)
    ) u_dec (
        .io_req(io_req), .wr_en(wr_en), .io_addr(cpu_addr[IO_W-1:0]),
        .page_we(page_we), .ctrl_we(ctrl_we)
    );

    pmu_page_regs #(.NUM_BLK(NUM_BLK), .PAGE_W(PAGE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .page_we(page_we),
        .wdata(cpu_wdata[PAGE_W-1:0]), .pages_flat(pages_flat)
    );

    pmu_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
        .enable_bit(cpu_wdata[0]), .paged(paged)
    );

    assign blk         = cpu_addr[ADDR_W-1:OFS_W];
    assign bypass_page = (boot_sram ? FLASH_END : '0) + PAGE_W'(blk);

    always_comb begin
        if (paged) page_sel = pages_flat[blk*PAGE_W +: PAGE_W];
        else       page_sel = bypass_page;
    end

    assign phys_addr = {page_sel, cpu_addr[OFS_W-1:0]};
    assign flash_cs  = mem_req && (page_sel < FLASH_END);
    assign sram_cs   = mem_req && (page_sel >= FLASH_END) && (page_sel < SRAM_END);
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 8,
    parameter int OFS_W       = 14,
    parameter int NUM_BLK     = 4,
    parameter int FLASH_PAGES = 32,
    parameter int PAGE_BASE   = 'h60,
    parameter int CTRL_BASE   = 'h64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         cpu_addr,
    input logic [7:0]                cpu_wdata,
    input logic                      mem_req,
    input logic                      io_req,
    input logic                      wr_en,
    input logic                      boot_sram,
    input logic [PAGE_W+OFS_W-1:0]   phys_addr,
    input logic                      flash_cs,
    input logic                      sram_cs,
    input logic                      paged,
    input logic [NUM_BLK*PAGE_W-1:0] pages_flat
);
    localparam logic [7:0] P0   = 8'(PAGE_BASE);
    localparam logic [7:0] P3   = 8'(PAGE_BASE + 3);
    localparam logic [7:0] C0   = 8'(CTRL_BASE);
    localparam logic [7:0] C1   = 8'(CTRL_BASE + 1);
    localparam logic [PAGE_W-3:0] RAM_HI = (PAGE_W-2)'(FLASH_PAGES >> 2);

    logic io_wr, ctrl_hit;
    assign io_wr    = io_req && wr_en;
    assign ctrl_hit = io_wr && (cpu_addr[7:0] == C0 || cpu_addr[7:0] == C1);

    AST_PAGE0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && cpu_addr[7:0] == P0 |=> pages_flat[PAGE_W-1:0] == $past(cpu_wdata[PAGE_W-1:0])); // R2
    AST_PAGE3_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && cpu_addr[7:0] == P3 |=> pages_flat[4*PAGE_W-1:3*PAGE_W] == $past(cpu_wdata[PAGE_W-1:0])); // R2
    AST_MODE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit && cpu_wdata[0] |=> paged); // R6
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit && !cpu_wdata[0] |=> !paged); // R6
    AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flash_cs, sram_cs})); // R7
    AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> !flash_cs && !sram_cs); // R7
    AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]); // R1
    AST_BYPASS_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        !paged |-> phys_addr[PAGE_W+OFS_W-1:OFS_W+2] == (boot_sram ? RAM_HI : '0)); // R5
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(pages_flat) && $stable(paged)); // R8
endmodule

bind page_map_unit pmu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_req(mem_req), .io_req(io_req), .wr_en(wr_en), .boot_sram(boot_sram),
    .phys_addr(phys_addr), .flash_cs(flash_cs), .sram_cs(sram_cs),
    .paged(paged), .pages_flat(pages_flat)
);

// File: tb/tb_page_map_unit.sv
`timescale 1ns/1ps
module tb_page_map_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        mem_req = 1'b0, io_req = 1'b0, wr_en = 1'b0, boot_sram = 1'b0;
    logic [21:0] phys_addr;
    logic        flash_cs, sram_cs;

    int n_run = 0, n_fail = 0;
    int ref_pages [4];
    bit ref_paged;

    always #2.5 clk = ~clk;

    page_map_unit dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .mem_req(mem_req), .io_req(io_req), .wr_en(wr_en), .boot_sram(boot_sram),
        .phys_addr(phys_addr), .flash_cs(flash_cs), .sram_cs(sram_cs)
    );

    task automatic model_reset();
        ref_paged = 0;
        for (int k = 0; k < 4; k++) ref_pages[k] = k;
    endtask

    // drive at the falling edge, compare before the rising edge, then update model
    task automatic step(string tag, logic [15:0] a, logic [7:0] d,
                        bit m, bit io, bit w, bit strap);
        int page, blk, exp_phys;
        bit exp_f, exp_s;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; mem_req = m; io_req = io; wr_en = w; boot_sram = strap;
        #1;
        blk  = int'(a[15:14]);
        page = ref_paged ? ref_pages[blk] : ((strap ? 32 : 0) + blk);
        exp_phys = page * 16384 + int'(a[13:0]);
        exp_f = m && page < 32;
        exp_s = m && page >= 32 && page < 64;
        n_run++;
        if (int'(phys_addr) != exp_phys || flash_cs != exp_f || sram_cs != exp_s) begin
            n_fail++;
            $display("FAIL %s: phys=%h cs(f,s)=%b%b expected phys=%h cs(f,s)=%b%b",
                     tag, phys_addr, flash_cs, sram_cs, exp_phys[21:0], exp_f, exp_s);
        end
        @(posedge clk);
        if (io && w) begin
            if (a[7:0] >= 8'h60 && a[7:0] <= 8'h63) ref_pages[int'(a[7:0]) - 'h60] = int'(d);
            if (a[7:0] == 8'h64 || a[7:0] == 8'h65) ref_paged = d[0];
        end
    endtask

    task automatic rd(string tag, logic [15:0] a, bit strap);
        step(tag, a, 8'h00, 1'b1, 1'b0, 1'b0, strap);
    endtask

    task automatic iow(string tag, logic [15:0] a, logic [7:0] d);
        step(tag, a, d, 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R4 reset state, R9 same-cycle response, R5 flash bypass
        rd("R4", 16'h0000, 0);
        rd("R9", 16'h4123, 0);
        rd("R5", 16'h8ABC, 0);
        rd("R5", 16'hFFFF, 0);
        // R5 static RAM bypass via strap
        for (int k = 0; k < 4; k++) rd("R5", 16'(k * 16'h4000 + 16'h0155), 1);
        // R7 idle selects
        step("R7", 16'h1234, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

        // R6 enable before programming; R3 strap ignored, R4 identity regs
        iow("R6", 16'h0064, 8'h01);
        for (int k = 0; k < 4; k++) rd("R3", 16'(k * 16'h4000 + 16'h2A5A), 1);

        // R2 program all windows; high address byte ignored (R8)
        iow("R2", 16'hAB60, 8'd35);
        iow("R2", 16'h0061, 8'd5);
        iow("R2", 16'h0062, 8'd200);
        iow("R2", 16'h0063, 8'd63);
        rd("R3", 16'h0001, 0);
        rd("R1", 16'h7FFE, 0);
        rd("R7", 16'h8000, 0);
        rd("R7", 16'hC3C3, 1);
        rd("R8", 16'h0000, 0);

        // R7 boundaries: 31 flash, 32 RAM, 64 none
        iow("R7", 16'h0061, 8'd31);
        rd("R7", 16'h4000, 0);
        iow("R7", 16'h0061, 8'd32);
        rd("R7", 16'h4000, 0);
        iow("R7", 16'h0061, 8'd64);
        rd("R7", 16'h4000, 0);
        iow("R2", 16'h0061, 8'd5);

        // R8 decoys: I/O read, memory write, neighbouring ports
        step("R8", 16'h0060, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0);
        step("R8", 16'h0061, 8'h98, 1'b1, 1'b0, 1'b1, 1'b0);
        iow("R8", 16'h005F, 8'h97);
        iow("R8", 16'h0066, 8'h00);
        step("R8", 16'h0064, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) rd("R8", 16'(k * 16'h4000 + 16'h0777), 0);

        // R6 disable through 65h with other bits set, then re-enable
        iow("R6", 16'h0065, 8'hFE);
        rd("R6", 16'h0000, 0);
        rd("R6", 16'hC000, 1);
        iow("R6", 16'h0065, 8'h01);
        for (int k = 0; k < 4; k++) rd("R6", 16'(k * 16'h4000 + 16'h1F0F), 1);

        // R4 reset again restores identity map and bypass
        @(negedge clk); rst_n = 1'b0;
        model_reset();
        @(negedge clk); rst_n = 1'b1;
        rd("R4", 16'hC010, 0);
        iow("R4", 16'h0064, 8'h01);
        rd("R4", 16'hC010, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule